// File: doc/BRIEF.md
# Inter-Queue Flag Synchronizer

This block gives a set of issue queues the means to order their work among themselves. Each queue's issue stage presents at most one synchronization instruction per cycle: a flag post, a flag wait or a barrier. In the same cycle the block answers whether that instruction may retire. While the answer is no, the stage holds the instruction and everything behind it. The queues are numbered 0 to NQ-1. Between every ordered pair of distinct queues, a poster and a waiter, there are NID single-bit flags. With the defaults that gives 5 x 4 x 4 = 80 bits.

The block also counts each queue's outstanding memory operations. It increments on an issue pulse and decrements on a completion pulse. A post and a barrier are released only when their own queue has nothing outstanding. A wait consumes its flag. A post that finds its flag already raised records a sticky overflow. An instruction whose kind is reserved, or which names itself or a nonexistent queue as peer, is retired at once and does nothing.

Top module: `qflag_sync`

## Requirements
- R1: Once reset has been released, every flag reads 0, every outstanding count is 0, `flag_ovf` is 0, and `sync_go` is 0 while no instruction is valid.
- R2: A post (kind 0) from queue q names a peer p and an id i. When q has no outstanding memory operations, the post retires in the same cycle, and flag (q to p, i) reads 1 from the next cycle on.
- R3: A post from a queue with a non-zero outstanding count does not retire. The count rises by one for each `mem_issue` pulse and falls by one for each `mem_done` pulse. The post retires in the first cycle in which the registered count is 0.
- R4: A wait (kind 1) in queue q names the posting queue p and an id i. If flag (p to q, i) is 0, the wait does not retire. If the flag is 1, the wait retires in that cycle and the flag returns to 0, so a second wait on the same flag blocks.
- R5: A barrier (kind 2) retires only in a cycle in which its own queue's outstanding count is 0.
- R6: A post and a wait that meet on the same flag in one cycle both retire, and the flag ends at 0.
- R7: A post that retires while its flag already reads 1 leaves the flag at 1. It sets `flag_ovf` one cycle later, and `flag_ovf` stays at 1 until reset.
- R8: Flags are distinct for each ordered pair and each id. A post to (p to q, i) releases neither a wait for another id, nor a wait in another queue, nor a wait in the opposite direction.
- R9: An instruction of kind 3, or a post or wait whose peer equals its own queue or is NQ or more, retires in the same cycle and changes no flag.
- R10: An issue pulse and a completion pulse in the same cycle on one queue leave that queue's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_issue | input | NQ | Per queue: one memory operation issued this cycle |
| mem_done | input | NQ | Per queue: one memory operation completed this cycle |
| sync_valid | input | NQ | Per queue: a synchronization instruction is presented |
| sync_kind | input | 2*NQ | Per queue, 2 bits: 0 post, 1 wait, 2 barrier, 3 reserved |
| sync_peer | input | PW*NQ | Per queue: the other queue of the pair (waiter for a post, poster for a wait) |
| sync_id | input | IW*NQ | Per queue: flag id within the pair |
| sync_go | output | NQ | Per queue: the presented instruction retires this cycle |
| flag_ovf | output | 1 | Sticky: a post found its flag already raised |

## Verification
Two functions can fall in the same cycle. One queue can post a flag while the waiting queue consumes it. The bench provokes this by presenting the post and the wait on the same flag together. It expects both queues to retire, and it expects a repeated wait in the next cycle to block, which shows the flag ended at 0. The second case is a completion pulse arriving in the same cycle as a blocked post or barrier, or together with an issue pulse. The bench expects the instruction to stay blocked in that cycle and to retire only once the registered count has reached zero.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

  typedef enum logic [1:0] {
    SK_POST = 2'd0,
    SK_WAIT = 2'd1,
    SK_BAR  = 2'd2,
    SK_RSV  = 2'd3
  } sync_kind_e;

endpackage

// File: rtl/qfs_op_tracker.sv
module qfs_op_tracker #(
  parameter int CW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic done,
  output logic idle
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = issue ^ done;
    if (issue && !done) begin
      cnt_d = cnt_q + 1'b1;
    end else if (done && !issue) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle = (cnt_q == '0);

  // R3: a completion never arrives with nothing outstanding
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !issue) |-> (cnt_q != '0));

  // R3: the counter is wide enough for the traffic
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !done) |-> (cnt_q != '1));

  // R10: simultaneous issue and completion cancel
  p_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && done) |=> $stable(cnt_q));

endmodule

// File: rtl/qfs_flag_bank.sv
module qfs_flag_bank #(
  parameter int NF = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags,
  output logic          ovf
);

  logic [NF-1:0] flags_d;
  logic          flags_en;
  logic          ovf_d;
  logic          dup_post;

  always_comb begin
    flags_d  = (flags | set_vec) & ~clr_vec;
    flags_en = (|set_vec) | (|clr_vec);
    dup_post = |(set_vec & flags);
    ovf_d    = ovf | dup_post;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (dup_post) begin
      ovf <= ovf_d;
    end
  end

  // R4: only a raised or just-posted flag is ever consumed
  p_clr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~(flags | set_vec)) == '0));

  // R7: overflow is sticky
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R7: a post onto a raised flag records overflow
  p_ovf_on_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & flags)) |=> ovf);

  for (genvar b = 0; b < NF; b++) begin : g_bit_chk
    // R6: a consume in the same cycle as a post leaves the flag at 0
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[b] |=> !flags[b]);
    // R2: a post without a consume raises the flag
    p_post_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[b] && !clr_vec[b]) |=> flags[b]);
  end

endmodule

// File: rtl/qflag_sync.sv
module qflag_sync
  import qfs_pkg::*;
#(
  parameter int NQ  = 5,
  parameter int NID = 4,
  parameter int CW  = 6,
  parameter int PW  = $clog2(NQ + 1),
  parameter int IW  = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    mem_issue,
  input  logic [NQ-1:0]    mem_done,
  input  logic [NQ-1:0]    sync_valid,
  input  logic [2*NQ-1:0]  sync_kind,
  input  logic [PW*NQ-1:0] sync_peer,
  input  logic [IW*NQ-1:0] sync_id,
  output logic [NQ-1:0]    sync_go,
  output logic             flag_ovf
);

  localparam int NF  = NQ * (NQ - 1) * NID;
  localparam int FXW = (NF > 1) ? $clog2(NF) : 1;

  function automatic logic [FXW-1:0] fidx(input int poster, input int waiter, input int id);
    int slot;
    slot = (waiter < poster) ? waiter : waiter - 1;
    return FXW'((poster * (NQ - 1) + slot) * NID + id);
  endfunction

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  // per-queue outstanding memory operation trackers
  logic [NQ-1:0] q_idle;

  for (genvar q = 0; q < NQ; q++) begin : g_trk
    qfs_op_tracker #(.CW(CW)) trk_i (
      .clk   (clk),
      .rst_n (rst_core_n),
      .issue (mem_issue[q]),
      .done  (mem_done[q]),
      .idle  (q_idle[q])
    );
  end

  // field extraction
  sync_kind_e    kind_a [NQ];
  logic [PW-1:0] peer_a [NQ];
  logic [IW-1:0] id_a   [NQ];
  logic [NQ-1:0] peer_ok;

  for (genvar q = 0; q < NQ; q++) begin : g_fld
    assign kind_a[q]  = sync_kind_e'(sync_kind[2*q +: 2]);
    assign peer_a[q]  = sync_peer[PW*q +: PW];
    assign id_a[q]    = sync_id[IW*q +: IW];
    assign peer_ok[q] = (int'(peer_a[q]) < NQ) && (int'(peer_a[q]) != q);
  end

  // release decisions
  logic [NF-1:0] set_vec;
  logic [NF-1:0] clr_vec;
  logic [NF-1:0] flags;
  logic [NQ-1:0] post_fire;
  logic [NQ-1:0] wait_fire;
  logic [NQ-1:0] bar_fire;
  logic [NQ-1:0] bad_fire;
  logic [FXW-1:0] widx;

  always_comb begin
    set_vec   = '0;
    clr_vec   = '0;
    post_fire = '0;
    wait_fire = '0;
    bar_fire  = '0;
    bad_fire  = '0;
    widx      = '0;
    for (int q = 0; q < NQ; q++) begin
      if (sync_valid[q]) begin
        unique case (kind_a[q])
          SK_POST: begin
            if (!peer_ok[q]) begin
              bad_fire[q] = 1'b1;
            end else if (q_idle[q]) begin
              post_fire[q] = 1'b1;
              set_vec[fidx(q, int'(peer_a[q]), int'(id_a[q]))] = 1'b1;
            end
          end
          SK_BAR:  bar_fire[q] = q_idle[q];
          SK_RSV:  bad_fire[q] = 1'b1;
          default: ;
        endcase
      end
    end
    for (int q = 0; q < NQ; q++) begin
      if (sync_valid[q] && kind_a[q] == SK_WAIT) begin
        if (!peer_ok[q]) begin
          bad_fire[q] = 1'b1;
        end else begin
          widx = fidx(int'(peer_a[q]), q, int'(id_a[q]));
          if (flags[widx] || set_vec[widx]) begin
            wait_fire[q] = 1'b1;
            clr_vec[widx] = 1'b1;
          end
        end
      end
    end
    sync_go = post_fire | wait_fire | bar_fire | bad_fire;
  end

  qfs_flag_bank #(.NF(NF)) bank_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags),
    .ovf     (flag_ovf)
  );

  // R1: nothing retires without a presented instruction
  p_go_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((sync_go & ~sync_valid) == '0));

  // R8: at most one flag consumed per waiting queue, never more than queues
  p_clr_bounded_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    ($countones(clr_vec) <= NQ));

  // R9: a malformed instruction never touches the flags
  p_bad_no_touch_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((bad_fire != '0) && (post_fire == '0) && (wait_fire == '0)) |-> (set_vec == '0 && clr_vec == '0));

endmodule

// File: tb/qflag_sync_tb_top.sv
module qflag_sync_tb_top;

  localparam int NQ = 5;
  localparam int PW = 3;
  localparam int IW = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NQ-1:0]    mem_issue, mem_done, sync_valid, sync_go;
  logic [2*NQ-1:0]  sync_kind;
  logic [PW*NQ-1:0] sync_peer;
  logic [IW*NQ-1:0] sync_id;
  logic             flag_ovf;

  always #2.5 clk = ~clk;

  qflag_sync dut_i (
    .clk(clk), .rst_n(rst_n), .mem_issue(mem_issue), .mem_done(mem_done),
    .sync_valid(sync_valid), .sync_kind(sync_kind), .sync_peer(sync_peer),
    .sync_id(sync_id), .sync_go(sync_go), .flag_ovf(flag_ovf)
  );

  typedef struct {
    logic [NQ-1:0] go;
    logic          ovf;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  logic [NQ-1:0]    st_issue, st_done, st_valid;
  logic [2*NQ-1:0]  st_kind;
  logic [PW*NQ-1:0] st_peer;
  logic [IW*NQ-1:0] st_id;

  task automatic clear_stage();
    st_issue = '0; st_done = '0; st_valid = '0;
    st_kind = '0; st_peer = '0; st_id = '0;
  endtask

  task automatic put(input int q, input logic [1:0] k, input int p, input int i);
    st_valid[q]          = 1'b1;
    st_kind[2*q +: 2]    = k;
    st_peer[PW*q +: PW]  = PW'(p);
    st_id[IW*q +: IW]    = IW'(i);
  endtask

  task automatic cyc(input logic [NQ-1:0] eg, input logic eo, input string tag);
    exp_t e;
    @(negedge clk);
    mem_issue  = st_issue;
    mem_done   = st_done;
    sync_valid = st_valid;
    sync_kind  = st_kind;
    sync_peer  = st_peer;
    sync_id    = st_id;
    e.go = eg; e.ovf = eo; e.tag = tag;
    sbq.push_back(e);
    clear_stage();
  endtask

  // monitor: compares each cycle's outputs against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_checks++;
        if (sync_go !== e.go || flag_ovf !== e.ovf) begin
          n_errors++;
          $display("FAIL %s: go=%b ovf=%b expected go=%b ovf=%b",
                   e.tag, sync_go, flag_ovf, e.go, e.ovf);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    clear_stage();
    rst_n = 1'b0;
    mem_issue = '0; mem_done = '0; sync_valid = '0;
    sync_kind = '0; sync_peer = '0; sync_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    cyc(5'b00000, 1'b0, "R1 idle after reset");
    // R4: wait on empty flag blocks
    put(1, 2'd1, 0, 2);
    cyc(5'b00000, 1'b0, "R4 wait on cleared flag");
    // R6: post and wait meet
    put(0, 2'd0, 1, 2); put(1, 2'd1, 0, 2);
    cyc(5'b00011, 1'b0, "R6 post and wait same cycle");
    put(1, 2'd1, 0, 2);
    cyc(5'b00000, 1'b0, "R6 flag ended at zero");
    // R3/R5: outstanding operation
    st_issue[0] = 1'b1;
    cyc(5'b00000, 1'b0, "R3 issue only");
    put(0, 2'd0, 1, 1); put(2, 2'd2, 0, 0);
    cyc(5'b00100, 1'b0, "R3 post blocked, R5 idle barrier");
    put(0, 2'd0, 1, 1); st_done[0] = 1'b1;
    cyc(5'b00000, 1'b0, "R3 completion cycle still blocked");
    put(0, 2'd0, 1, 1);
    cyc(5'b00001, 1'b0, "R3 post retires at zero count");
    put(1, 2'd1, 0, 1);
    cyc(5'b00010, 1'b0, "R2 wait sees posted flag");
    put(1, 2'd1, 0, 1);
    cyc(5'b00000, 1'b0, "R4 flag consumed");
    // R8: distinct flags
    put(3, 2'd0, 4, 0);
    cyc(5'b01000, 1'b0, "R2 post 3 to 4");
    put(4, 2'd1, 3, 1); put(2, 2'd1, 3, 0); put(3, 2'd1, 4, 0);
    cyc(5'b00000, 1'b0, "R8 other id, queue, direction");
    put(4, 2'd1, 3, 0);
    cyc(5'b10000, 1'b0, "R8 matching wait");
    // R7: overflow
    put(2, 2'd0, 0, 3);
    cyc(5'b00100, 1'b0, "R7 first post");
    put(2, 2'd0, 0, 3);
    cyc(5'b00100, 1'b0, "R7 second post");
    cyc(5'b00000, 1'b1, "R7 overflow raised");
    put(0, 2'd1, 2, 3);
    cyc(5'b00001, 1'b1, "R7 flag still raised");
    put(0, 2'd1, 2, 3);
    cyc(5'b00000, 1'b1, "R7 single flag only");
    // R9: malformed
    put(1, 2'd0, 1, 0); put(2, 2'd1, 6, 0); put(3, 2'd3, 0, 0);
    cyc(5'b01110, 1'b1, "R9 malformed retire");
    put(0, 2'd1, 1, 0);
    cyc(5'b00000, 1'b1, "R9 no flag touched");
    // R10 and R5 blocking
    st_issue[4] = 1'b1;
    cyc(5'b00000, 1'b1, "R10 issue");
    st_issue[4] = 1'b1; st_done[4] = 1'b1;
    cyc(5'b00000, 1'b1, "R10 issue and done");
    put(4, 2'd2, 0, 0);
    cyc(5'b00000, 1'b1, "R10 count still one, R5 barrier blocks");
    put(4, 2'd2, 0, 0); st_done[4] = 1'b1;
    cyc(5'b00000, 1'b1, "R5 barrier with completion");
    put(4, 2'd2, 0, 0);
    cyc(5'b10000, 1'b1, "R5 barrier retires");
    cyc(5'b00000, 1'b1, "R7 overflow sticky");

    wait (sbq.size() == 0);
    #10;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule